// File: doc/BRIEF.md
# Serial Audio Control Register Receiver

This block takes control words for an analog volume, tone and source-select stage from a three-wire serial link made of a frame enable line, a serial clock and a data line. The three lines come from another clock domain. They are synchronized to the system clock, and data is sampled on each rising edge of the serial clock while enable is high. One frame holds 40 bits, sent least significant bit first. The first 8 bits are a device address and the remaining 32 bits are a data word.

The block checks the frame when enable falls. If exactly 40 bits arrived and the address matches the `DEV_ADDR` parameter, every control output is loaded from the data word in the same cycle and a one-cycle commit pulse is raised. Any other frame is dropped and the outputs keep their values.

Field values outside their legal range are clamped before they reach the outputs. From reset until the first accepted frame the block holds a mute flag high, because the analog switches have no defined state until then.

Top module: `sctl_rx`

## Requirements
- R1: Data bits are sampled on rising serial-clock edges while enable is high, least significant bit first. The first 8 bits form the address and the next 32 form the data word. Outputs change only after enable falls.
- R2: A frame whose address differs from `DEV_ADDR` is discarded, and all outputs keep their previous values.
- R3: A frame whose bit count is not exactly 40 when enable falls is discarded, for example 39 or 41 bits. All outputs keep their previous values.
- R4: Serial-clock and data activity while enable is low has no effect on any output.
- R5: Data bits [4:0] carry the left volume code and bits [9:5] carry the right volume code. Code 0 is 0 dB and code 24 is full attenuation. Codes 25 to 31 are clamped to 24.
- R6: Data bits [13:10], [17:14], [21:18], [25:22] and [29:26] carry the equalizer codes for bands 0 to 4. A code k means a gain of 2k−10 dB, and codes 11 to 15 are clamped to 10. Band b appears on `eq_bands[4b+3:4b]`.
- R7: Data bits [31:30] carry the input select, where 0 means input 1 and 3 means input 4.
- R8: `mute` is high from reset until the first accepted frame. After that it stays low.
- R9: `commit_pulse` is high for exactly one cycle for each accepted frame. It is never high for a discarded frame.
- R10: While `rst_n` is low, the block sets both volumes to 24, all equalizer bands to 5 (flat), the select to 0 and `mute` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en | input | 1 | Serial frame enable, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| vol_left | output | 5 | Left attenuation code |
| vol_right | output | 5 | Right attenuation code |
| eq_bands | output | 20 | Five 4-bit equalizer codes |
| src_sel | output | 2 | Input select |
| mute | output | 1 | High until the first accepted frame |
| commit_pulse | output | 1 | One-cycle pulse on each accepted frame |

## Verification
The bench builds the block with `DEV_ADDR` set to 8'h3C and `SYNC_STAGES` left at 2. This lets a mismatching address, differing in a single bit, be tested next to the accepted one. The volume sweep covers all 32 codes and the equalizer sweep covers all 16 codes in every band, so every clamp boundary is reached. Frames of 39 and 41 bits, and serial activity with enable low, test the discard paths against a model that changes only when a frame is accepted.

// File: rtl/sctl_pkg.sv
// Package: shared constants for the serial control receiver.
// Assumes: field widths below match the 32-bit data word layout.
package sctl_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int VOL_W   = 5;
    localparam int VOL_MAX = 24;   // full attenuation code
    localparam int EQ_W    = 4;
    localparam int EQ_MAX  = 10;
    localparam int EQ_FLAT = 5;    // 0 dB
    localparam int BANDS   = 5;
    localparam int SEL_W   = 2;
endpackage

// File: rtl/sctl_sync.sv
// Module: multi-flop synchronizer for asynchronous input lines.
// Assumes: each line is a level that is stable for many system clocks.
module sctl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // Purpose: move the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sctl_shifter.sv
// Module: edge detection, LSB-first frame shift register and bit counter.
// Assumes: synchronized inputs; counter saturates one past the frame length
// so that overlong frames remain distinguishable.
module sctl_shifter #(
    parameter int FRAME_BITS = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_s,
    input  logic                  sck_s,
    input  logic                  dat_s,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  done_o,
    output logic                  len_ok_o
);
    localparam int CNT_W   = $clog2(FRAME_BITS + 2);
    localparam int CNT_TOP = FRAME_BITS + 1;

    logic             en_d, sck_d;
    logic [CNT_W-1:0] cnt;
    logic             en_rise, sck_rise;

    assign en_rise  = en_s & ~en_d;
    assign sck_rise = sck_s & ~sck_d;
    assign done_o   = en_d & ~en_s;
    assign len_ok_o = (cnt == CNT_W'(FRAME_BITS));

    // Purpose: remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d  <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            en_d  <= en_s;
            sck_d <= sck_s;
        end
    end

    // Purpose: clear on frame start, shift and count on rising serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            frame_o <= '0;
        end else if (en_rise) begin
            cnt <= '0;
        end else if (en_s && sck_rise) begin
            frame_o <= {dat_s, frame_o[FRAME_BITS-1:1]};
            if (cnt != CNT_W'(CNT_TOP)) cnt <= cnt + 1'b1;
        end
    end

    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(CNT_TOP));
    a_r1_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (cnt == '0));
    a_r4_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !en_rise) |=> $stable(cnt));
endmodule

// File: rtl/sctl_clamp.sv
// Module: splits the data word into control fields and clamps each field.
// Assumes: the fields fill the data word from bit 0 upward.
module sctl_clamp
    import sctl_pkg::*;
(
    input  logic [DATA_W-1:0]     data_i,
    output logic [VOL_W-1:0]      vol_l_o,
    output logic [VOL_W-1:0]      vol_r_o,
    output logic [BANDS*EQ_W-1:0] eq_o,
    output logic [SEL_W-1:0]      sel_o
);
    localparam int EQ_BASE  = 2 * VOL_W;
    localparam int SEL_BASE = EQ_BASE + BANDS * EQ_W;

    logic [VOL_W-1:0] raw_l, raw_r;

    assign raw_l = data_i[VOL_W-1:0];
    assign raw_r = data_i[2*VOL_W-1:VOL_W];

    // Purpose: clamp both volume codes to the full-attenuation code.
    always_comb begin
        vol_l_o = (raw_l > VOL_W'(VOL_MAX)) ? VOL_W'(VOL_MAX) : raw_l;
        vol_r_o = (raw_r > VOL_W'(VOL_MAX)) ? VOL_W'(VOL_MAX) : raw_r;
    end

    for (genvar b = 0; b < BANDS; b++) begin : g_band
        logic [EQ_W-1:0] raw;
        assign raw = data_i[EQ_BASE + b*EQ_W +: EQ_W];
        // Purpose: clamp this band to the maximum boost code.
        always_comb
            eq_o[b*EQ_W +: EQ_W] = (raw > EQ_W'(EQ_MAX)) ? EQ_W'(EQ_MAX) : raw;
    end

    assign sel_o = data_i[SEL_BASE +: SEL_W];
endmodule

// File: rtl/sctl_rx.sv
// Module: top level of the serial control receiver. It synchronizes the
// link, stages the frame and commits the fields when enable falls.
// Assumes: the serial clock is much slower than clk (several clocks per phase).
module sctl_rx
    import sctl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'hA5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_en,
    input  logic                  ser_clk,
    input  logic                  ser_dat,
    output logic [VOL_W-1:0]      vol_left,
    output logic [VOL_W-1:0]      vol_right,
    output logic [BANDS*EQ_W-1:0] eq_bands,
    output logic [SEL_W-1:0]      src_sel,
    output logic                  mute,
    output logic                  commit_pulse
);
    localparam int FRAME_BITS = ADDR_W + DATA_W;

    logic [2:0]              sync_q;
    logic [FRAME_BITS-1:0]   frame;
    logic                    done, len_ok, accept;
    logic [VOL_W-1:0]        nx_l, nx_r;
    logic [BANDS*EQ_W-1:0]   nx_eq;
    logic [SEL_W-1:0]        nx_sel;

    sctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({frame_en, ser_clk, ser_dat}),
        .q_o   (sync_q)
    );

    sctl_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_s     (sync_q[2]),
        .sck_s    (sync_q[1]),
        .dat_s    (sync_q[0]),
        .frame_o  (frame),
        .done_o   (done),
        .len_ok_o (len_ok)
    );

    sctl_clamp u_clamp (
        .data_i  (frame[FRAME_BITS-1:ADDR_W]),
        .vol_l_o (nx_l),
        .vol_r_o (nx_r),
        .eq_o    (nx_eq),
        .sel_o   (nx_sel)
    );

    assign accept = done & len_ok & (frame[ADDR_W-1:0] == DEV_ADDR);

    // Purpose: load all control outputs together when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_left     <= VOL_W'(VOL_MAX);
            vol_right    <= VOL_W'(VOL_MAX);
            eq_bands     <= {BANDS{EQ_W'(EQ_FLAT)}};
            src_sel      <= '0;
            mute         <= 1'b1;
            commit_pulse <= 1'b0;
        end else begin
            commit_pulse <= accept;
            if (accept) begin
                vol_left  <= nx_l;
                vol_right <= nx_r;
                eq_bands  <= nx_eq;
                src_sel   <= nx_sel;
                mute      <= 1'b0;
            end
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> !commit_pulse);
    a_r8_mute_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !mute |=> !mute);
    a_r8_unmute_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute) |-> commit_pulse);
    a_r2_hold_between_commits: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_pulse |-> ($stable(vol_left) && $stable(vol_right)
                           && $stable(eq_bands) && $stable(src_sel)));
    a_r5_vol_range: assert property (@(posedge clk) disable iff (!rst_n)
        (vol_left <= VOL_W'(VOL_MAX)) && (vol_right <= VOL_W'(VOL_MAX)));

    for (genvar b = 0; b < BANDS; b++) begin : g_chk
        a_r6_eq_range: assert property (@(posedge clk) disable iff (!rst_n)
            eq_bands[b*EQ_W +: EQ_W] <= EQ_W'(EQ_MAX));
    end
endmodule

// File: tb/sctl_rx_tb.sv
// Bench: sweeps volume and equalizer codes, address, length and idle cases
// against an arithmetic model that changes only on accepted frames.
module sctl_rx_tb;
    localparam int         CLK_PERIOD = 10;
    localparam int         HALF       = 4;   // system clocks per serial phase
    localparam logic [7:0] ADDR       = 8'h3C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic [4:0]  vol_left, vol_right;
    logic [19:0] eq_bands;
    logic [1:0]  src_sel;
    logic        mute, commit_pulse;

    int checks = 0, fails = 0, pulses = 0;
    logic prev_pulse = 1'b0;
    bit   done_flag = 1'b0;

    logic [4:0]  m_l, m_r;
    logic [19:0] m_eq;
    logic [1:0]  m_sel;
    logic        m_mute;

    always #(CLK_PERIOD/2) clk = ~clk;

    sctl_rx #(.DEV_ADDR(ADDR), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .vol_left(vol_left), .vol_right(vol_right),
        .eq_bands(eq_bands), .src_sel(src_sel), .mute(mute),
        .commit_pulse(commit_pulse)
    );

    // Pulse monitor: counts pulses and flags any pulse longer than a cycle (R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (commit_pulse) pulses++;
            if (commit_pulse && prev_pulse) begin
                fails++;
                $display("FAIL R9 pulse width >1 cycle: actual 1 expected 0");
            end
            prev_pulse <= commit_pulse;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " vol_left"},  32'(vol_left),  32'(m_l));
        check({req, " vol_right"}, 32'(vol_right), 32'(m_r));
        check({req, " eq_bands"},  32'(eq_bands),  32'(m_eq));
        check({req, " src_sel"},   32'(src_sel),   32'(m_sel));
        check({req, " mute"},      32'(mute),      32'(m_mute));
    endtask

    function automatic logic [4:0] clv(int v);
        return (v > 24) ? 5'd24 : 5'(v);
    endfunction
    function automatic logic [3:0] cle(int v);
        return (v > 10) ? 4'd10 : 4'(v);
    endfunction

    // Sends nbits of {data,addr} LSB first; bits beyond 40 are zero.
    task automatic send(logic [7:0] a, logic [31:0] d, int nbits);
        logic [39:0] f;
        f = {d, a};
        frame_en = 1'b1;
        repeat (HALF) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = (i < 40) ? f[i] : 1'b0;
            repeat (HALF) @(posedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(posedge clk);
            ser_clk = 1'b0;
        end
        repeat (HALF) @(posedge clk);
        frame_en = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
    endtask

    // Sends a frame and checks outputs and pulse count against the model.
    task automatic frame_chk(string req, logic [7:0] a, logic [31:0] d, int nbits);
        int p0;
        logic ok;
        p0 = pulses;
        ok = (a == ADDR) && (nbits == 40);
        send(a, d, nbits);
        if (ok) begin
            m_l = clv(int'(d[4:0]));
            m_r = clv(int'(d[9:5]));
            for (int b = 0; b < 5; b++) m_eq[4*b +: 4] = cle(int'(d[10+4*b +: 4]));
            m_sel  = d[31:30];
            m_mute = 1'b0;
        end
        check_all(req);
        check({req, " R9 pulses"}, 32'(pulses - p0), ok ? 32'd1 : 32'd0);
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] d;
        m_l = 5'd24; m_r = 5'd24; m_eq = {5{4'd5}}; m_sel = 2'd0; m_mute = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_all("R10 reset");
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R10 after release");

        // Discarded frames before the first accept keep mute high (R8, R2, R3).
        frame_chk("R2 wrong addr", ADDR ^ 8'h01, 32'h1234_5678, 40);
        frame_chk("R3 short 39",   ADDR, 32'h0000_0021, 39);
        frame_chk("R8 first valid", ADDR, 32'h4000_0000 | (32'd3 << 5) | 32'd7, 40);

        // R5 volume sweep with clamp, R7 select rotation, R1 layout.
        for (int v = 0; v < 32; v++) begin
            d = '0;
            d[4:0]   = 5'(v);
            d[9:5]   = 5'(31 - v);
            for (int b = 0; b < 5; b++) d[10+4*b +: 4] = 4'((v + b) % 11);
            d[31:30] = 2'(v % 4);
            frame_chk("R5 R7 vol sweep", ADDR, d, 40);
        end

        // R6 equalizer sweep over all codes in every band.
        for (int e = 0; e < 16; e++) begin
            d = '0;
            for (int b = 0; b < 5; b++) d[10+4*b +: 4] = 4'((e + 3*b) % 16);
            d[4:0] = 5'(e);
            d[9:5] = 5'(e + 9);
            d[31:30] = 2'(3 - e % 4);
            frame_chk("R6 eq sweep", ADDR, d, 40);
        end

        // R3 long frame and R2 address variants do not disturb state.
        frame_chk("R3 long 41", ADDR, 32'hFFFF_FFFF, 41);
        frame_chk("R2 addr high bit", ADDR ^ 8'h80, 32'h0, 40);
        frame_chk("R1 accepted after discards", ADDR, 32'h8A5A_5A41, 40);

        // R4 serial activity while enable low.
        begin
            int p0;
            p0 = pulses;
            for (int i = 0; i < 45; i++) begin
                ser_dat = i[0];
                repeat (HALF) @(posedge clk);
                ser_clk = 1'b1;
                repeat (HALF) @(posedge clk);
                ser_clk = 1'b0;
            end
            repeat (10) @(posedge clk);
            @(negedge clk);
            check_all("R4 idle clocks");
            check("R4 R9 no pulse", 32'(pulses - p0), 32'd0);
        end
        frame_chk("R4 frame after idle", ADDR, 32'h0000_0000, 40);
        check("R8 mute stays low", 32'(mute), 32'd0);

        report();
    end
endmodule